// File: doc/BRIEF.md
# Branch and Stack Control Unit

This block decides where an 8-bit machine with fixed four-byte instructions fetches next. It also owns a private 256-entry stack for call, return, push and pop. Each cycle it receives one decoded instruction: the opcode byte, two source operand values (already resolved from register or immediate), the third instruction byte and the current program counter. From these it produces the next program counter. It also produces the stack strobes, the stack address and the write data. A popped value comes out together with the register index it is bound for.

The upper two opcode bits only choose where the operands come from, and that choice is made before this block. Decoding therefore looks only at the low six bits. Conditional branches compare the two operands as unsigned numbers. The stack pointer grows upward: it points at the next free slot and wraps silently at both ends.

Top module: `flowctl_unit`

## Requirements
- R1: After reset the stack pointer is 0, so the first push writes stack address 0x00. An instruction with no flow effect yields next PC = PC + 4, wrapping modulo 256 (for example 0xFC gives 0x00).
- R2: Low opcode bits 100000 (equal) and 100001 (not equal) set the next PC to byte 3 when the condition holds between operand A and operand B. Otherwise the next PC is PC + 4.
- R3: Low opcode bits 100010 (A<B), 100011 (A<=B), 100100 (A>B) and 100101 (A>=B) branch to byte 3 when the condition holds. The comparison is unsigned, so 0x80 is greater than 0x7F.
- R4: Low opcode bits 100110 always set the next PC to byte 3, whatever the operand values. No stack strobe is raised.
- R5: Low opcode bits 110000 (push) raise the write strobe. They drive the stack address with SP and the write data with operand A, then increment SP. The next PC is PC + 4.
- R6: Low opcode bits 110001 (pop) raise the read strobe and drive the stack address with SP-1. They present the value stored there on the pop data output, the register index from byte 3 and the pop write enable, then decrement SP. Values come back in last-in first-out order.
- R7: Low opcode bits 110010 (call) push PC + 4 at SP and set the next PC to byte 3.
- R8: Low opcode bits 110101 (return) read the stack at SP-1, load the next PC from that value and decrement SP. All three operand bytes are ignored, and the pop write enable stays low.
- R9: SP wraps silently. A pop at SP 0x00 reads address 0xFF, and a push at 0xFF returns SP to 0x00.
- R10: Opcode bits 7:6 do not affect decoding. Any other low-bit pattern (for example 000000 or 010000) raises no stack strobe and leaves the stack contents and SP unchanged. The read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 8 | Opcode byte |
| opa_i | input | DATA_W | Resolved first source operand |
| opb_i | input | DATA_W | Resolved second source operand |
| tgt_i | input | ADDR_W | Third instruction byte: target address or register index |
| pc_i | input | ADDR_W | Current program counter |
| next_pc_o | output | ADDR_W | Program counter for the following fetch |
| stk_wr_o | output | 1 | Stack write strobe (push, call) |
| stk_rd_o | output | 1 | Stack read strobe (pop, return) |
| stk_addr_o | output | STK_AW | Stack slot addressed this cycle |
| stk_wdata_o | output | DATA_W | Value written to the stack |
| pop_data_o | output | DATA_W | Value stored at the top of the stack |
| pop_reg_o | output | ADDR_W | Destination register index of a pop |
| pop_we_o | output | 1 | Pop result is to be written to pop_reg_o |

## Verification
The next PC, the strobes, the stack address, the write data and the pop outputs are combinational in the presented instruction, so they are due in the same cycle as that stimulus. A change of stack pointer or stack contents becomes visible only after the following rising edge. The bench therefore changes inputs just after a falling edge and samples one nanosecond later, before the rising edge. Stack pointer effects are checked through the address and data of the next instruction. In this way every value is read in the cycle it is due, and never across an edge where it could change.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;

   localparam logic [5:0] FC_JEQ  = 6'b100000;
   localparam logic [5:0] FC_JNE  = 6'b100001;
   localparam logic [5:0] FC_JLT  = 6'b100010;
   localparam logic [5:0] FC_JLE  = 6'b100011;
   localparam logic [5:0] FC_JGT  = 6'b100100;
   localparam logic [5:0] FC_JGE  = 6'b100101;
   localparam logic [5:0] FC_JMP  = 6'b100110;
   localparam logic [5:0] FC_PUSH = 6'b110000;
   localparam logic [5:0] FC_POP  = 6'b110001;
   localparam logic [5:0] FC_CALL = 6'b110010;
   localparam logic [5:0] FC_RET  = 6'b110101;

   typedef enum logic [2:0] {
      CMP_EQ = 3'd0,
      CMP_NE = 3'd1,
      CMP_LT = 3'd2,
      CMP_LE = 3'd3,
      CMP_GT = 3'd4,
      CMP_GE = 3'd5
   } cmp_e;

   typedef struct packed {
      logic branch;
      logic jump;
      logic push;
      logic pop;
      logic call;
      logic ret;
      cmp_e cond;
   } fc_ctl_t;

   function automatic fc_ctl_t fc_decode(input logic [5:0] low);
      fc_ctl_t c;
      c = '{branch: 1'b0, jump: 1'b0, push: 1'b0, pop: 1'b0,
            call: 1'b0, ret: 1'b0, cond: CMP_EQ};
      case (low)
         FC_JEQ, FC_JNE, FC_JLT, FC_JLE, FC_JGT, FC_JGE: begin
            c.branch = 1'b1;
            c.cond   = cmp_e'(low[2:0]);
         end
         FC_JMP:  c.jump = 1'b1;
         FC_PUSH: c.push = 1'b1;
         FC_POP:  c.pop  = 1'b1;
         FC_CALL: c.call = 1'b1;
         FC_RET:  c.ret  = 1'b1;
         default: ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/flowctl_decode.sv
module flowctl_decode
   import flowctl_pkg::*;
(
   input  logic [5:0] low_i,
   output fc_ctl_t    ctl_o
);

   always_comb ctl_o = fc_decode(low_i);

endmodule

// File: rtl/flowctl_cond.sv
module flowctl_cond
   import flowctl_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter bit          CMP_SIGNED = 1'b0
) (
   input  cmp_e              sel_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic              hit_o
);

   logic eq, lt;

   assign eq = (a_i == b_i);

   generate
      if (CMP_SIGNED) begin : g_signed
         assign lt = ($signed(a_i) < $signed(b_i));
      end else begin : g_unsigned
         assign lt = (a_i < b_i);
      end
   endgenerate

   always_comb begin
      case (sel_i)
         CMP_EQ:  hit_o = eq;
         CMP_NE:  hit_o = !eq;
         CMP_LT:  hit_o = lt;
         CMP_LE:  hit_o = lt || eq;
         CMP_GT:  hit_o = !(lt || eq);
         CMP_GE:  hit_o = !lt;
         default: hit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/flowctl_stack.sv
module flowctl_stack #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [AW-1:0]     sp_o,
   output logic [AW-1:0]     addr_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [AW-1:0]     sp_q;
   logic [AW-1:0]     sp_dec;
   logic [DATA_W-1:0] mem [DEPTH];

   assign sp_dec  = sp_q - AW'(1);
   assign addr_o  = rd_i ? sp_dec : sp_q;
   assign rdata_o = mem[sp_dec];
   assign sp_o    = sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sp_q <= '0;
      else if (wr_i) sp_q <= sp_q + AW'(1);
      else if (rd_i) sp_q <= sp_dec;
   end

   always_ff @(posedge clk) begin
      if (wr_i) mem[sp_q] <= wdata_i;
   end

endmodule

// File: rtl/flowctl_unit.sv
module flowctl_unit
   import flowctl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned STK_AW     = 8,
   parameter int unsigned INSN_BYTES = 4,
   parameter bit          CMP_SIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        op_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [ADDR_W-1:0] tgt_i,
   input  logic [ADDR_W-1:0] pc_i,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic              stk_wr_o,
   output logic              stk_rd_o,
   output logic [STK_AW-1:0] stk_addr_o,
   output logic [DATA_W-1:0] stk_wdata_o,
   output logic [DATA_W-1:0] pop_data_o,
   output logic [ADDR_W-1:0] pop_reg_o,
   output logic              pop_we_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

   generate
      if (ADDR_W > DATA_W) begin : g_bad_width
         $error("flowctl_unit: a return address must fit in one stack word");
      end
      if (INSN_BYTES == 0) begin : g_bad_step
         $error("flowctl_unit: INSN_BYTES must be nonzero");
      end
      if (STK_AW == 0 || STK_AW > 12) begin : g_bad_depth
         $error("flowctl_unit: STK_AW out of range");
      end
   endgenerate

   fc_ctl_t           ctl;
   logic              hit;
   logic [ADDR_W-1:0] seq_pc;
   logic [STK_AW-1:0] sp_w;
   logic              unused_src_sel;

   assign unused_src_sel = ^op_i[7:6];

   flowctl_decode u_dec (
      .low_i (op_i[5:0]),
      .ctl_o (ctl)
   );

   flowctl_cond #(
      .DATA_W     (DATA_W),
      .CMP_SIGNED (CMP_SIGNED)
   ) u_cond (
      .sel_i (ctl.cond),
      .a_i   (opa_i),
      .b_i   (opb_i),
      .hit_o (hit)
   );

   assign seq_pc      = pc_i + STEP;
   assign stk_wr_o    = ctl.push || ctl.call;
   assign stk_rd_o    = ctl.pop || ctl.ret;
   assign stk_wdata_o = ctl.call ? DATA_W'(seq_pc) : opa_i;

   flowctl_stack #(
      .DATA_W (DATA_W),
      .AW     (STK_AW)
   ) u_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (stk_wr_o),
      .rd_i    (stk_rd_o),
      .wdata_i (stk_wdata_o),
      .sp_o    (sp_w),
      .addr_o  (stk_addr_o),
      .rdata_o (pop_data_o)
   );

   assign pop_reg_o = tgt_i;
   assign pop_we_o  = ctl.pop;

   always_comb begin
      if (ctl.ret)                                 next_pc_o = pop_data_o[ADDR_W-1:0];
      else if (ctl.jump || ctl.call)               next_pc_o = tgt_i;
      else if (ctl.branch && hit)                  next_pc_o = tgt_i;
      else                                         next_pc_o = seq_pc;
   end

endmodule

// File: rtl/flowctl_unit_chk.sv
module flowctl_unit_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned STK_AW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stk_wr,
   input logic              stk_rd,
   input logic              pop_we,
   input logic [ADDR_W-1:0] next_pc,
   input logic [DATA_W-1:0] pop_data,
   input logic [DATA_W-1:0] stk_wdata,
   input logic [STK_AW-1:0] sp
);

   // R10: never read and write in the same cycle
   p_excl_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stk_wr, stk_rd}));

   // R10: stack pointer holds when no strobe is raised
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!stk_wr && !stk_rd) |=> $stable(sp));

   // R5: a write advances the stack pointer by one
   p_push_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stk_wr |=> sp == $past(sp) + STK_AW'(1));

   // R5: the value just written becomes the top of stack
   p_push_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stk_wr |=> pop_data == $past(stk_wdata));

   // R6: a read moves the stack pointer back by one
   p_pop_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stk_rd |=> sp == $past(sp) - STK_AW'(1));

   // R6: a register write only accompanies a stack read
   p_popwe_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop_we |-> stk_rd);

   // R8: a read without register write is a return and reloads the PC
   p_ret_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_rd && !pop_we) |-> next_pc == pop_data[ADDR_W-1:0]);

endmodule

bind flowctl_unit flowctl_unit_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .STK_AW (STK_AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .stk_wr    (stk_wr_o),
   .stk_rd    (stk_rd_o),
   .pop_we    (pop_we_o),
   .next_pc   (next_pc_o),
   .pop_data  (pop_data_o),
   .stk_wdata (stk_wdata_o),
   .sp        (sp_w)
);

// File: tb/flowctl_unit_test.sv
`timescale 1ns/1ps
module flowctl_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] op_i = 8'h00, opa_i = 8'h00, opb_i = 8'h00, tgt_i = 8'h00, pc_i = 8'h00;
   logic [7:0] next_pc_o, stk_addr_o, stk_wdata_o, pop_data_o, pop_reg_o;
   logic       stk_wr_o, stk_rd_o, pop_we_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   flowctl_unit uut (
      .clk (clk), .rst_n (rst_n), .op_i (op_i), .opa_i (opa_i), .opb_i (opb_i),
      .tgt_i (tgt_i), .pc_i (pc_i), .next_pc_o (next_pc_o),
      .stk_wr_o (stk_wr_o), .stk_rd_o (stk_rd_o), .stk_addr_o (stk_addr_o),
      .stk_wdata_o (stk_wdata_o), .pop_data_o (pop_data_o),
      .pop_reg_o (pop_reg_o), .pop_we_o (pop_we_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] t, input logic [7:0] pc);
      @(negedge clk);
      op_i = op; opa_i = a; opb_i = b; tgt_i = t; pc_i = pc;
      #1;
   endtask

   function automatic bit cond_ref(input int c, input logic [7:0] a, input logic [7:0] b);
      case (c)
         0: return a == b;
         1: return a != b;
         2: return a < b;
         3: return a <= b;
         4: return a > b;
         default: return a >= b;
      endcase
   endfunction

   task automatic t_seq;
      drive(8'h00, 8'h12, 8'h34, 8'h56, 8'h10);
      chk("R1 seq pc", next_pc_o, 8'h14);
      chk("R10 no strobe", {stk_wr_o, stk_rd_o, pop_we_o}, 3'b000);
      drive(8'h00, 8'h00, 8'h00, 8'h00, 8'hFC);
      chk("R1 pc wrap", next_pc_o, 8'h00);
      drive(8'h50, 8'h01, 8'h02, 8'h03, 8'h40);
      chk("R10 other opcode pc", next_pc_o, 8'h44);
      chk("R10 other opcode strobes", {stk_wr_o, stk_rd_o, pop_we_o}, 3'b000);
   endtask

   task automatic t_push_pop;
      drive(8'h30, 8'h11, 8'h99, 8'h00, 8'h20);
      chk("R1 first push at 0", stk_addr_o, 8'h00);
      chk("R5 push strobe", {stk_wr_o, stk_rd_o}, 2'b10);
      chk("R5 push data", stk_wdata_o, 8'h11);
      chk("R5 push pc", next_pc_o, 8'h24);
      drive(8'h00, 8'hAA, 8'hBB, 8'h00, 8'h24);   // R10 no effect on stack
      drive(8'h70, 8'h22, 8'h00, 8'h00, 8'h28);
      chk("R5 second push addr", stk_addr_o, 8'h01);
      drive(8'hB0, 8'h33, 8'h00, 8'h00, 8'h2C);
      chk("R10 push with high bits addr", stk_addr_o, 8'h02);
      chk("R10 push with high bits data", stk_wdata_o, 8'h33);
      drive(8'h31, 8'h00, 8'h00, 8'h05, 8'h30);
      chk("R6 pop strobe", {stk_wr_o, stk_rd_o, pop_we_o}, 3'b011);
      chk("R6 pop addr", stk_addr_o, 8'h02);
      chk("R6 pop data", pop_data_o, 8'h33);
      chk("R6 pop reg", pop_reg_o, 8'h05);
      chk("R6 pop pc", next_pc_o, 8'h34);
      drive(8'h31, 8'h00, 8'h00, 8'h09, 8'h34);
      chk("R6 lifo second", pop_data_o, 8'h22);
      chk("R6 lifo addr", stk_addr_o, 8'h01);
      drive(8'hF1, 8'h00, 8'h00, 8'h0A, 8'h38);
      chk("R6 lifo third", pop_data_o, 8'h11);
      chk("R6 lifo third addr", stk_addr_o, 8'h00);
   endtask

   task automatic t_cond;
      for (int c = 0; c < 6; c++) begin
         for (int k = 0; k < 4; k++) begin
            logic [7:0] a, b, op, exp;
            string tag;
            case (k)
               0: begin a = 8'h05; b = 8'h05; end
               1: begin a = 8'h05; b = 8'h06; end
               2: begin a = 8'h80; b = 8'h7F; end
               default: begin a = 8'h7F; b = 8'h80; end
            endcase
            op  = 8'h20 | 8'(c) | ((k == 3) ? 8'hC0 : 8'h00);
            exp = cond_ref(c, a, b) ? 8'h40 : 8'h0C;
            tag = (c < 2) ? "R2 eq/ne branch" : "R3 unsigned order branch";
            drive(op, a, b, 8'h40, 8'h08);
            chk(tag, next_pc_o, exp);
            chk("R10 branch no strobe", {stk_wr_o, stk_rd_o}, 2'b00);
         end
      end
   endtask

   task automatic t_jump;
      drive(8'h26, 8'h01, 8'hFF, 8'h9C, 8'h50);
      chk("R4 jump target", next_pc_o, 8'h9C);
      drive(8'hE6, 8'hFF, 8'h01, 8'h04, 8'hF8);
      chk("R4 jump ignores operands", next_pc_o, 8'h04);
      chk("R4 jump no strobe", {stk_wr_o, stk_rd_o}, 2'b00);
   endtask

   task automatic t_call_ret;
      drive(8'h32, 8'h06, 8'h00, 8'h80, 8'h20);
      chk("R7 call target", next_pc_o, 8'h80);
      chk("R7 call strobe", {stk_wr_o, stk_rd_o}, 2'b10);
      chk("R7 call addr", stk_addr_o, 8'h00);
      chk("R7 call pushes pc+4", stk_wdata_o, 8'h24);
      drive(8'h32, 8'h06, 8'h00, 8'hC0, 8'hFC);
      chk("R7 nested call data wraps", stk_wdata_o, 8'h00);
      chk("R7 nested call addr", stk_addr_o, 8'h01);
      drive(8'h35, 8'h11, 8'h22, 8'h33, 8'hC0);
      chk("R8 ret inner pc", next_pc_o, 8'h00);
      chk("R8 ret strobe", {stk_wr_o, stk_rd_o, pop_we_o}, 3'b010);
      drive(8'hF5, 8'hAB, 8'hCD, 8'hEF, 8'h00);
      chk("R8 ret outer pc", next_pc_o, 8'h24);
      chk("R8 ret addr", stk_addr_o, 8'h00);
   endtask

   task automatic t_wrap;
      drive(8'h31, 8'h00, 8'h00, 8'h01, 8'h60);
      chk("R9 pop underflow addr", stk_addr_o, 8'hFF);
      drive(8'h30, 8'h5A, 8'h00, 8'h00, 8'h64);
      chk("R9 push at top addr", stk_addr_o, 8'hFF);
      drive(8'h31, 8'h00, 8'h00, 8'h02, 8'h68);
      chk("R9 sp wrapped to 0, pop addr", stk_addr_o, 8'hFF);
      chk("R9 wrapped pop data", pop_data_o, 8'h5A);
      drive(8'h00, 8'h00, 8'h00, 8'h00, 8'h6C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_seq();
      t_push_pop();
      t_cond();
      t_jump();
      t_call_ret();
      t_wrap();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule